// File: doc/BRIEF.md
# Circular Capture Buffer Writer

This block takes a stream of 32-bit capture words. It keeps one 16-bit field from each word, packs four of those samples into a 64-bit memory word, and queues the packed words in an on-chip FIFO. When the FIFO holds enough packed words to reach a programmable threshold, the block issues a burst of that many 64-bit writes on a request/grant write port. Each write goes to a pointer that advances by 8 bytes. After the buffer's last word is written, the pointer returns to the buffer's base.

Software supplies three addresses: the ring base, the first address to write, and the address of the last 64-bit word in the ring. The last-word address is inclusive. Raising the run bit copies the first-write address into the pointer, so each capture run starts from a known place. The pointer is always visible as an absolute byte address, and software subtracts the base from it to get its position in the ring. Lowering the run bit lets a burst that has already started finish, and then holds off any further bursts.

Top module: `capring_dma`

## Requirements
- R1: While reset is asserted, `mem_req` is 0, `pos_addr` is 0 and `in_ready` is 1.
- R2: Each accepted input word contributes bits 31:16 as one sample. Four consecutive samples form one 64-bit word: the first sample goes in bits 15:0, the second in 31:16, the third in 47:32 and the fourth in 63:48. The low 16 input bits never appear in memory.
- R3: On the first clock edge at which `cfg_run` is sampled 1 after being 0, `pos_addr` takes `cfg_init` with bits 2:0 forced to 0. The new value is visible after that edge.
- R4: A burst starts only when `cfg_run` is 1 and the FIFO holds at least `cfg_thresh` packed words. The burst is exactly `cfg_thresh` writes long. A threshold of 0 never starts a burst.
- R5: Each write completes in a cycle where `mem_req` and `mem_gnt` are both 1. It writes `mem_wdata` to `mem_addr`, which equals `pos_addr`. After that cycle, `pos_addr` advances by 8.
- R6: A write to the address equal to `cfg_last` is performed, and after it `pos_addr` becomes `cfg_base`.
- R7: While `mem_gnt` is 0, `mem_req` stays 1 and `mem_addr` and `mem_wdata` do not change.
- R8: If `cfg_run` falls during a burst, the burst completes all of its writes. After that, no new burst starts while `cfg_run` is 0.
- R9: While `cfg_last` is below `cfg_base`, which describes a ring shorter than one 8-byte word, no burst starts.
- R10: `in_ready` is 0 while the FIFO is full. No accepted sample is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | ADDR_W | Ring base byte address |
| cfg_init | input | ADDR_W | Address loaded into the pointer when the run bit rises |
| cfg_last | input | ADDR_W | Address of the last 64-bit word in the ring (inclusive) |
| cfg_run | input | 1 | Run bit: a rise reloads the pointer, and a level of 1 allows bursts |
| cfg_thresh | input | $clog2(DEPTH)+1 | FIFO fill level (in packed words) that triggers a burst, which is also the burst length |
| in_valid | input | 1 | Capture word valid |
| in_word | input | IN_W | Capture word |
| in_ready | output | 1 | Capture word accepted when high together with in_valid |
| mem_req | output | 1 | Write request |
| mem_addr | output | ADDR_W | Write byte address |
| mem_wdata | output | BUS_W | Write data |
| mem_gnt | input | 1 | Write grant, completing the write in the same cycle |
| pos_addr | output | ADDR_W | Current write pointer (absolute address) |

## Verification
A table of four input quadruples drives the packing and addressing path. The quadruples carry distinct upper halves, all-ones and all-zeros halves, and low halves that differ from the upper halves. Together they show whether the right field is taken, whether the lanes are placed in the right order, and whether the low halves leak into memory. Directed runs then vary the threshold (3, then 0, then 1) to separate "enough data" from "not enough". They also hold the grant low to expose a request that drifts, drop the run bit in the middle of a burst, and use an inverted ring and a three-word ring to check the invalid-buffer rule and the inclusive wrap. A final run fills the FIFO with grant low to show backpressure and lossless, in-order drain.

// File: rtl/capring_pkg.sv
package capring_pkg;
  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_FETCH = 2'd1,
    WS_WRITE = 2'd2
  } wr_state_t;
endpackage

// File: rtl/capring_packer.sv
module capring_packer #(
  parameter int SMP_W = 16,
  parameter int OUT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_fire,
  input  logic [SMP_W-1:0] sample,
  output logic             push,
  output logic [OUT_W-1:0] push_data
);
  localparam int LANES = OUT_W / SMP_W;
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LW-1:0]    lane;
  logic [OUT_W-1:0] acc;
  logic             last_lane;

  assign last_lane = (lane == LW'(LANES - 1));
  assign push      = in_fire && last_lane;

  always_ff @(posedge clk) begin
    if (rst) begin
      lane <= '0;
    end else if (in_fire) begin
      lane <= last_lane ? '0 : lane + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (in_fire) begin
      acc[lane*SMP_W +: SMP_W] <= sample;
    end
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      if (g == LANES - 1) begin : g_top
        assign push_data[g*SMP_W +: SMP_W] = sample;
      end else begin : g_low
        assign push_data[g*SMP_W +: SMP_W] = acc[g*SMP_W +: SMP_W];
      end
    end
  endgenerate

  // R2
  lane_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    push |=> (lane == '0));
endmodule

// File: rtl/capring_fifo.sv
module capring_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 128,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  assign full = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
    if (pop)  dout <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));
endmodule

// File: rtl/capring_writer.sv
module capring_writer
  import capring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 64,
  parameter int CW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_init,
  input  logic [ADDR_W-1:0] cfg_last,
  input  logic              cfg_run,
  input  logic [CW-1:0]     cfg_thresh,
  input  logic [CW-1:0]     fifo_cnt,
  output logic              fifo_rd,
  input  logic [BUS_W-1:0]  fifo_dout,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BUS_W-1:0]  mem_wdata,
  input  logic              mem_gnt,
  output logic [ADDR_W-1:0] pos_addr
);
  localparam int STEP = BUS_W / 8;
  localparam int OFS  = $clog2(STEP);

  wr_state_t         state;
  logic [CW-1:0]     beats_left;
  logic [ADDR_W-1:0] ptr, next_ptr, base_a, last_a, init_a;
  logic              run_q, run_rise, cfg_ok, trigger, beat;

  assign base_a   = {cfg_base[ADDR_W-1:OFS], OFS'(0)};
  assign last_a   = {cfg_last[ADDR_W-1:OFS], OFS'(0)};
  assign init_a   = {cfg_init[ADDR_W-1:OFS], OFS'(0)};
  assign run_rise = cfg_run && !run_q;
  assign cfg_ok   = (last_a >= base_a);
  assign trigger  = (state == WS_IDLE) && cfg_run && (cfg_thresh != '0) &&
                    (fifo_cnt >= cfg_thresh) && cfg_ok;
  assign beat     = (state == WS_WRITE) && mem_gnt;
  assign fifo_rd  = trigger || (beat && (beats_left != CW'(1)));
  assign next_ptr = (ptr == last_a) ? base_a : ptr + ADDR_W'(STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      ptr   <= '0;
    end else begin
      run_q <= cfg_run;
      if (run_rise)  ptr <= init_a;
      else if (beat) ptr <= next_ptr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= WS_IDLE;
      beats_left <= '0;
    end else begin
      case (state)
        WS_IDLE: if (trigger) begin
          beats_left <= cfg_thresh;
          state      <= WS_FETCH;
        end
        WS_FETCH: state <= WS_WRITE;
        WS_WRITE: if (mem_gnt) begin
          beats_left <= beats_left - 1'b1;
          state      <= (beats_left == CW'(1)) ? WS_IDLE : WS_FETCH;
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

  assign mem_req   = (state == WS_WRITE);
  assign mem_addr  = ptr;
  assign mem_wdata = fifo_dout;
  assign pos_addr  = ptr;

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt && !run_rise) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_wdata)));
  // R5
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (beat && !run_rise && (ptr != last_a)) |=> (ptr == $past(ptr) + ADDR_W'(STEP)));
  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (beat && !run_rise && (ptr == last_a)) |=> (ptr == $past(base_a)));
  // R3
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    run_rise |=> (pos_addr == $past(init_a)));
  // R8
  no_start_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == WS_IDLE) && !cfg_run) |=> (state != WS_FETCH));
  // R9
  bad_ring_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == WS_IDLE) && !cfg_ok) |=> (state == WS_IDLE));
  // R4
  below_thr_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == WS_IDLE) && (fifo_cnt < cfg_thresh)) |=> !mem_req);
endmodule

// File: rtl/capring_dma.sv
module capring_dma #(
  parameter int ADDR_W  = 32,
  parameter int IN_W    = 32,
  parameter int SMP_MSB = 31,
  parameter int SMP_LSB = 16,
  parameter int BUS_W   = 64,
  parameter int DEPTH   = 128,
  localparam int SMP_W  = SMP_MSB - SMP_LSB + 1,
  localparam int CW     = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_init,
  input  logic [ADDR_W-1:0] cfg_last,
  input  logic              cfg_run,
  input  logic [CW-1:0]     cfg_thresh,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_word,
  output logic              in_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BUS_W-1:0]  mem_wdata,
  input  logic              mem_gnt,
  output logic [ADDR_W-1:0] pos_addr
);
  logic             in_fire, push, pop, full;
  logic [BUS_W-1:0] push_data, fifo_dout;
  logic [CW-1:0]    fifo_cnt;

  assign in_ready = !full;
  assign in_fire  = in_valid && in_ready;

  capring_packer #(.SMP_W(SMP_W), .OUT_W(BUS_W)) u_pack (
    .clk(clk), .rst(rst), .in_fire(in_fire),
    .sample(in_word[SMP_MSB:SMP_LSB]),
    .push(push), .push_data(push_data)
  );

  capring_fifo #(.W(BUS_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(push_data),
    .pop(pop), .dout(fifo_dout), .count(fifo_cnt), .full(full)
  );

  capring_writer #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .CW(CW)) u_wr (
    .clk(clk), .rst(rst),
    .cfg_base(cfg_base), .cfg_init(cfg_init), .cfg_last(cfg_last),
    .cfg_run(cfg_run), .cfg_thresh(cfg_thresh),
    .fifo_cnt(fifo_cnt), .fifo_rd(pop), .fifo_dout(fifo_dout),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .pos_addr(pos_addr)
  );
endmodule

// File: tb/tb_capring_dma.sv
`timescale 1ns/1ps
module tb_capring_dma;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH) + 1;

  localparam logic [31:0] TV_IN [16] = '{
    32'h1111_AAAA, 32'h2222_BBBB, 32'h3333_CCCC, 32'h4444_DDDD,
    32'hFFFF_0000, 32'h0000_FFFF, 32'h8000_0001, 32'h7FFF_FFFE,
    32'h0001_0002, 32'h0003_0004, 32'h0005_0006, 32'h0007_0008,
    32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h1234_5678, 32'h9ABC_DEF0};
  localparam logic [63:0] TV_EXP [4] = '{
    64'h4444_3333_2222_1111, 64'h7FFF_8000_0000_FFFF,
    64'h0007_0005_0003_0001, 64'h9ABC_1234_CAFE_DEAD};

  logic clk = 0, rst = 1;
  logic [31:0] cfg_base = 0, cfg_init = 0, cfg_last = 0;
  logic cfg_run = 0;
  logic [CW-1:0] cfg_thresh = 0;
  logic in_valid = 0;
  logic [31:0] in_word = 0;
  logic in_ready, mem_req, mem_gnt = 0;
  logic [31:0] mem_addr, pos_addr;
  logic [63:0] mem_wdata;

  always #2 clk = ~clk;

  capring_dma #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_init(cfg_init),
    .cfg_last(cfg_last), .cfg_run(cfg_run), .cfg_thresh(cfg_thresh),
    .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .pos_addr(pos_addr));

  int tests = 0, fails = 0;
  int nbeats = 0, ngrp = 0, chk_idx = 0;
  logic [31:0] log_addr [64];
  logic [63:0] log_data [64];
  logic [63:0] exp_grp [64];
  logic [31:0] exp_ptr = 0;
  logic [15:0] sid = 16'h0100;
  bit done = 0;

  always @(negedge clk) begin
    if (!rst && mem_req && mem_gnt && nbeats < 64) begin
      log_addr[nbeats] = mem_addr;
      log_data[nbeats] = mem_wdata;
      nbeats++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_raw(input logic [31:0] w);
    in_valid = 1; in_word = w;
    forever begin
      @(negedge clk);
      if (in_ready) begin @(posedge clk); #1; break; end
    end
    in_valid = 0;
  endtask

  task automatic send_gen();
    logic [63:0] e;
    for (int k = 0; k < 4; k++) begin
      e[k*16 +: 16] = sid;
      send_raw({sid, ~sid});
      sid++;
    end
    exp_grp[ngrp] = e; ngrp++;
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] p);
    return (p == cfg_last) ? cfg_base : p + 32'd8;
  endfunction

  task automatic run_rise();
    cfg_run = 1; exp_ptr = {cfg_init[31:3], 3'b000}; cyc(2);
  endtask

  task automatic verify(input int n, input string tag);
    chk(nbeats == chk_idx + n, {tag, " beat count"}, 64'(nbeats), 64'(chk_idx + n));
    for (int k = chk_idx; k < chk_idx + n && k < nbeats; k++) begin
      chk(log_data[k] == exp_grp[k], {tag, " data"}, log_data[k], exp_grp[k]);
      chk(log_addr[k] == exp_ptr, {tag, " addr"}, 64'(log_addr[k]), 64'(exp_ptr));
      exp_ptr = nxt(exp_ptr);
    end
    chk_idx = nbeats;
  endtask

  initial begin
    #(4ns * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    cyc(3);
    // R1 reset state
    chk(mem_req == 0, "R1 mem_req", 64'(mem_req), 0);
    chk(pos_addr == 0, "R1 pos_addr", 64'(pos_addr), 0);
    chk(in_ready == 1, "R1 in_ready", 64'(in_ready), 1);
    rst = 0; cyc(2);

    // R3 reload with unaligned init
    cfg_base = 32'h1000; cfg_last = 32'h10F8; cfg_init = 32'h1013;
    cfg_thresh = 1; mem_gnt = 1;
    run_rise();
    chk(pos_addr == 32'h1010, "R3 reload", 64'(pos_addr), 64'h1010);

    // R2 R5 table of packing vectors
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < 4; k++) send_raw(TV_IN[i*4 + k]);
      exp_grp[ngrp] = TV_EXP[i]; ngrp++;
      cyc(10);
      verify(1, "R2/R5 table");
    end
    chk(pos_addr == exp_ptr, "R5 pos after table", 64'(pos_addr), 64'(exp_ptr));

    // R4 threshold 3
    cfg_thresh = 3;
    send_gen(); send_gen(); cyc(20);
    verify(0, "R4 below threshold");
    send_gen(); cyc(25);
    verify(3, "R4 burst of three");

    // R4 threshold 0 never triggers
    cfg_thresh = 0;
    send_gen(); cyc(20);
    verify(0, "R4 zero threshold");
    cfg_thresh = 1; cyc(10);
    verify(1, "R4 threshold back to one");

    // R7 request held without grant
    mem_gnt = 0;
    send_gen(); cyc(10);
    chk(mem_req == 1, "R7 req raised", 64'(mem_req), 1);
    held = mem_addr;
    cyc(5);
    chk(mem_req == 1 && mem_addr == held, "R7 req held", 64'(mem_addr), 64'(held));
    verify(0, "R7 no beat without grant");
    mem_gnt = 1; cyc(5);
    verify(1, "R7 beat after grant");

    // R8 run drop mid burst
    mem_gnt = 0; cfg_thresh = 2;
    send_gen(); send_gen(); cyc(10);
    chk(mem_req == 1, "R8 burst started", 64'(mem_req), 1);
    cfg_run = 0; cyc(3);
    mem_gnt = 1; cyc(15);
    verify(2, "R8 burst completes");
    send_gen(); send_gen(); cyc(20);
    verify(0, "R8 no new burst");

    // R9 inverted ring
    cfg_base = 32'h3000; cfg_last = 32'h2000; cfg_init = 32'h3000;
    run_rise(); cyc(20);
    verify(0, "R9 invalid ring");
    chk(pos_addr == 32'h3000, "R3 reload second", 64'(pos_addr), 64'h3000);
    cfg_last = 32'h3018; cyc(20);
    verify(2, "R9 valid ring");

    // R6 three-word ring, inclusive last
    cfg_run = 0; cfg_base = 32'h2000; cfg_last = 32'h2010; cfg_init = 32'h2008;
    cfg_thresh = 1; cyc(2);
    run_rise();
    send_gen(); send_gen(); send_gen(); cyc(15);
    verify(3, "R6 wrap");
    chk(pos_addr == 32'h2008, "R6 pos after wrap", 64'(pos_addr), 64'h2008);

    // R10 backpressure and lossless drain
    cfg_run = 0; cfg_base = 32'h4000; cfg_last = 32'h47F8; cfg_init = 32'h4000;
    mem_gnt = 0; cyc(2);
    run_rise();
    for (int g = 0; g < DEPTH + 1; g++) send_gen();
    cyc(5);
    chk(in_ready == 0, "R10 full blocks input", 64'(in_ready), 0);
    verify(0, "R10 no beat while stalled");
    mem_gnt = 1; cyc(4 * (DEPTH + 2) + 20);
    verify(DEPTH + 1, "R10 drain");
    chk(in_ready == 1, "R10 ready after drain", 64'(in_ready), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule